// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the programming and progress registers of one bus-master DMA channel in a storage host adapter. Software programs a starting byte count, a starting memory address and a starting descriptor address. It then issues a command. A start command copies those values into working copies, clears the sticky status and raises a transfer-enable line toward the data path. The memory-side master reports each burst it moves through a one-cycle transfer strobe that carries a byte count and a direction. The block clamps that count to the bytes still owed, counts the working count down and the working address up, and flags completion.

The status word has two clear policies, chosen by bit 24 of a separate control word. With bit 24 set, writing a one to a sticky flag clears it. With bit 24 clear, reading the status clears the flags, and writes to the status register do nothing. The status read also shows the live interrupt level of the attached bus core, which is never stored. A completion input from the core ends the transfer early. The flush and descriptor-list options are stored but have no effect. An abort command sends a single-cycle abort pulse to the core.

Top module: `dma_chan_regs`

## Requirements
- R1: Register index 0 is the command, 1 the start count, 2 the start address and 6 the start descriptor address. Each of these reads back the full 32-bit value last written to it. Read data is combinational from the stored state.
- R2: Writes to index 3 (working count), 4 (working address) and 7 (working descriptor address) leave those registers unchanged. While control bit 24 is clear, writes to index 5 (status) leave the status unchanged.
- R3: Writing the command with bits [1:0] = 3 (start) has these effects from the next cycle: the working count, working address and working descriptor address equal the start count, start address and start descriptor address; status bits 5..0 read zero; and `xfer_enable` is 1.
- R4: Command code 0 (idle) drops `xfer_enable`. Code 1 (flush) leaves `xfer_enable` and the working registers unchanged. Command bit 4 (descriptor mode) does not alter start behaviour.
- R5: Command code 2 (abort) drives `core_abort` high for exactly the one cycle after the write.
- R6: A transfer strobe of N bytes whose direction matches command bit 7 moves min(N, working count). `xfer_take` shows that amount in the strobe cycle. The working count then drops by it and the working address rises by it.
- R7: Status bit 3 (done) is set by an accepted transfer that leaves the working count at zero.
- R8: `xfer_dir` = 1 means device to memory, matching command bit 7 = 1. A strobe whose direction differs has `xfer_take` = 0 and changes no register.
- R9: With control bit 24 set, a write to status clears each of bits 1 (error), 2 (abort) and 3 (done) where the written value has a 1. The other flags stay as they are, and a status read clears nothing.
- R10: With control bit 24 clear, a status read returns the current flags and then clears bits 1, 2 and 3.
- R11: Status read bit 4 equals the present level of `core_irq` and is never stored.
- R12: A `core_done` pulse sets the working count to zero and sets status bit 3.
- R13: After reset the command reads 0, the working count 0, the working address 0xFFFFFFFF, the working descriptor address 0xFFFFFFFD, the status 0 and `xfer_enable` 0.
- R14: The control word reads back the value last written through `ctl_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (drives read-to-clear) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wdata | input | DW | Control word write data |
| ctl_rdata | output | DW | Control word read data |
| core_irq | input | 1 | Live interrupt level of the bus core |
| core_done | input | 1 | Command-completion pulse from the core |
| core_abort | output | 1 | One-cycle abort request to the core |
| xfer_enable | output | 1 | Transfer enabled toward the data path |
| xfer_valid | input | 1 | Transfer report strobe |
| xfer_dir | input | 1 | Transfer direction, 1 = device to memory |
| xfer_len | input | LW | Bytes offered in this report |
| xfer_take | output | DW | Bytes accepted in this report (clamped) |

## Verification
Read data and `xfer_take` are combinational, so they are valid in the same cycle as the index or strobe. The bench samples them one nanosecond after driving, and before the clock edge. Register updates, status changes, `xfer_enable` and the abort pulse appear in the cycle after the edge that captured the write, strobe or read. The bench drives every stimulus on a falling edge, holds it across one rising edge, and reads results after the next falling edge. `core_abort` is sampled on two falling edges in a row: high on the first and low on the second.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } op_e;

    localparam logic [2:0] IX_CMD  = 3'd0;
    localparam logic [2:0] IX_SCNT = 3'd1;
    localparam logic [2:0] IX_SADR = 3'd2;
    localparam logic [2:0] IX_WCNT = 3'd3;
    localparam logic [2:0] IX_WADR = 3'd4;
    localparam logic [2:0] IX_STAT = 3'd5;
    localparam logic [2:0] IX_SDSC = 3'd6;
    localparam logic [2:0] IX_WDSC = 3'd7;

    localparam int CMD_DIR_BIT = 7;
    localparam int CTL_W1C_BIT = 24;
    localparam int STAT_W      = 6;

    // status layout, bit 5 down to bit 0
    typedef struct packed {
        logic blk;
        logic core;
        logic done;
        logic abrt;
        logic err;
        logic pwdn;
    } stat_t;

    localparam logic [STAT_W-1:0] STICKY_MASK = 6'b001110;

    typedef struct packed {
        logic start;
        logic idle;
        logic abort;
    } cmd_evt_t;

    function automatic cmd_evt_t decode_op(input logic [1:0] code);
        cmd_evt_t e;
        e = '0;
        case (op_e'(code))
            OP_START: e.start = 1'b1;
            OP_IDLE:  e.idle  = 1'b1;
            OP_ABORT: e.abort = 1'b1;
            default:  e       = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/dcr_cmd_dec.sv
module dcr_cmd_dec
    import dcr_pkg::*;
(
    input  logic       wr_en,
    input  logic [2:0] idx,
    input  logic [1:0] code,
    output logic       cmd_wr,
    output cmd_evt_t   evt
);
    always_comb begin
        cmd_wr = wr_en && (idx == IX_CMD);
        evt    = cmd_wr ? decode_op(code) : '0;
    end
endmodule

// File: rtl/dcr_xfer_acct.sv
module dcr_xfer_acct #(
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          valid,
    input  logic          dir,
    input  logic          cmd_dir,
    input  logic [LW-1:0] len,
    input  logic [DW-1:0] wcnt,
    input  logic [DW-1:0] wadr,
    output logic          hit,
    output logic [DW-1:0] take,
    output logic [DW-1:0] wcnt_nxt,
    output logic [DW-1:0] wadr_nxt,
    output logic          empty
);
    localparam int PAD = DW - LW;

    logic [DW-1:0] len_x;

    always_comb begin
        len_x    = {{PAD{1'b0}}, len};
        hit      = valid && (dir == cmd_dir);
        take     = hit ? ((len_x < wcnt) ? len_x : wcnt) : '0;
        wcnt_nxt = wcnt - take;
        wadr_nxt = wadr + take;
        empty    = (wcnt_nxt == '0);
    end
endmodule

// File: rtl/dcr_status.sv
module dcr_status
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              set_done,
    input  logic [STAT_W-1:0] clr_mask,
    output stat_t             stat
);
    stat_t nxt;

    always_comb begin
        nxt = stat_t'(stat & ~(clr_mask & STICKY_MASK));
        if (set_done) nxt.done = 1'b1;
        if (start)    nxt      = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic          reg_rd_en,
    input  logic [2:0]    reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ctl_wr_en,
    input  logic [DW-1:0] ctl_wdata,
    output logic [DW-1:0] ctl_rdata,
    input  logic          core_irq,
    input  logic          core_done,
    output logic          core_abort,
    output logic          xfer_enable,
    input  logic          xfer_valid,
    input  logic          xfer_dir,
    input  logic [LW-1:0] xfer_len,
    output logic [DW-1:0] xfer_take
);
    localparam logic [DW-1:0] WADR_RST = '1;
    localparam logic [DW-1:0] WDSC_RST = ~DW'(2);

    logic [DW-1:0] cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, sdsc_q, wdsc_q, ctl_q;
    logic          cmd_wr;
    cmd_evt_t      evt;
    logic          hit, empty;
    logic [DW-1:0] wcnt_nxt, wadr_nxt;
    logic          w1c_mode;
    logic [STAT_W-1:0] clr_mask;
    logic          set_done;
    stat_t         stat_q, stat_rd;

    dcr_cmd_dec u_dec (
        .wr_en  (reg_wr_en),
        .idx    (reg_idx),
        .code   (reg_wdata[1:0]),
        .cmd_wr (cmd_wr),
        .evt    (evt)
    );

    dcr_xfer_acct #(.DW(DW), .LW(LW)) u_acct (
        .valid    (xfer_valid),
        .dir      (xfer_dir),
        .cmd_dir  (cmd_q[CMD_DIR_BIT]),
        .len      (xfer_len),
        .wcnt     (wcnt_q),
        .wadr     (wadr_q),
        .hit      (hit),
        .take     (xfer_take),
        .wcnt_nxt (wcnt_nxt),
        .wadr_nxt (wadr_nxt),
        .empty    (empty)
    );

    always_comb begin
        w1c_mode = ctl_q[CTL_W1C_BIT];
        clr_mask = '0;
        if (w1c_mode && reg_wr_en && reg_idx == IX_STAT)
            clr_mask = reg_wdata[STAT_W-1:0];
        else if (!w1c_mode && reg_rd_en && reg_idx == IX_STAT)
            clr_mask = STICKY_MASK;
        set_done = core_done || (hit && empty);
    end

    dcr_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .start    (evt.start),
        .set_done (set_done),
        .clr_mask (clr_mask),
        .stat     (stat_q)
    );

    // programmable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            scnt_q <= '0;
            sadr_q <= '0;
            sdsc_q <= '0;
            ctl_q  <= '0;
        end else begin
            if (cmd_wr) cmd_q <= reg_wdata;
            if (reg_wr_en && reg_idx == IX_SCNT) scnt_q <= reg_wdata;
            if (reg_wr_en && reg_idx == IX_SADR) sadr_q <= reg_wdata;
            if (reg_wr_en && reg_idx == IX_SDSC) sdsc_q <= reg_wdata;
            if (ctl_wr_en) ctl_q <= ctl_wdata;
        end
    end

    // working registers: start beats completion beats transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            wadr_q <= WADR_RST;
            wdsc_q <= WDSC_RST;
        end else if (evt.start) begin
            wcnt_q <= scnt_q;
            wadr_q <= sadr_q;
            wdsc_q <= sdsc_q;
        end else begin
            if (core_done)  wcnt_q <= '0;
            else if (hit)   wcnt_q <= wcnt_nxt;
            if (hit)        wadr_q <= wadr_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_enable <= 1'b0;
            core_abort  <= 1'b0;
        end else begin
            core_abort <= evt.abort;
            if (evt.start)     xfer_enable <= 1'b1;
            else if (evt.idle) xfer_enable <= 1'b0;
        end
    end

    always_comb begin
        stat_rd      = stat_q;
        stat_rd.core = stat_q.core | core_irq;
        case (reg_idx)
            IX_CMD:  reg_rdata = cmd_q;
            IX_SCNT: reg_rdata = scnt_q;
            IX_SADR: reg_rdata = sadr_q;
            IX_WCNT: reg_rdata = wcnt_q;
            IX_WADR: reg_rdata = wadr_q;
            IX_STAT: reg_rdata = {{(DW-STAT_W){1'b0}}, stat_rd};
            IX_SDSC: reg_rdata = sdsc_q;
            default: reg_rdata = wdsc_q;
        endcase
        ctl_rdata = ctl_q;
    end

endmodule

// File: rtl/dcr_chk.sv
module dcr_chk
    import dcr_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr_en,
    input logic          reg_rd_en,
    input logic [2:0]    reg_idx,
    input logic [DW-1:0] reg_wdata,
    input logic          w1c_mode,
    input logic          core_done,
    input logic          xfer_valid,
    input logic          xfer_dir,
    input logic          cmd_dir,
    input logic [DW-1:0] wcnt,
    input logic [DW-1:0] wadr,
    input logic [DW-1:0] scnt,
    input logic [STAT_W-1:0] stat,
    input logic          xfer_enable,
    input logic          core_abort
);
    logic start_wr, acc, quiet;
    always_comb begin
        start_wr = reg_wr_en && reg_idx == IX_CMD && reg_wdata[1:0] == 2'd3;
        acc      = xfer_valid && (xfer_dir == cmd_dir);
        quiet    = !reg_wr_en && !core_done;
    end

    AST_START_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (wcnt == $past(scnt)) && xfer_enable && (stat == '0)); // R3
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        core_abort |=> !core_abort); // R5
    AST_XFER_CONSERVES: assert property (@(posedge clk) disable iff (rst)
        (acc && quiet) |=> (wcnt + wadr) == $past(wcnt + wadr)); // R6
    AST_COUNT_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        !start_wr |=> wcnt <= $past(wcnt)); // R6
    AST_DIR_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !acc && quiet) |=> $stable(wcnt) && $stable(wadr)); // R8
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_idx == IX_STAT && !w1c_mode && !xfer_valid && quiet)
        |=> stat[3:1] == 3'b000); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_idx == IX_STAT && w1c_mode && !xfer_valid && !core_done)
        |=> stat[3:1] == ($past(stat[3:1]) & ~$past(reg_wdata[3:1]))); // R9
    AST_COMPLETION: assert property (@(posedge clk) disable iff (rst)
        (core_done && !start_wr) |=> (wcnt == '0) && stat[3]); // R12
    AST_RESET_WADR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wadr == '1) && !xfer_enable); // R13
endmodule

bind dma_chan_regs dcr_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .w1c_mode    (w1c_mode),
    .core_done   (core_done),
    .xfer_valid  (xfer_valid),
    .xfer_dir    (xfer_dir),
    .cmd_dir     (cmd_q[7]),
    .wcnt        (wcnt_q),
    .wadr        (wadr_q),
    .scnt        (scnt_q),
    .stat        (stat_q),
    .xfer_enable (xfer_enable),
    .core_abort  (core_abort)
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/100ps
module tb_dma_chan_regs;
    localparam int DW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr_en = 0, reg_rd_en = 0;
    logic [2:0] reg_idx = 0;
    logic [DW-1:0] reg_wdata = 0, ctl_wdata = 0;
    logic ctl_wr_en = 0, core_irq = 0, core_done = 0;
    logic xfer_valid = 0, xfer_dir = 0;
    logic [LW-1:0] xfer_len = 0;
    logic [DW-1:0] reg_rdata, ctl_rdata, xfer_take;
    logic core_abort, xfer_enable;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    dma_chan_regs #(.DW(DW), .LW(LW)) dut (.*);

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic ctl(input logic [DW-1:0] d);
        @(negedge clk);
        ctl_wr_en = 1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [DW-1:0] v);
        @(negedge clk);
        reg_rd_en = 1; reg_idx = i;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd_en = 0;
    endtask

    task automatic xfer(input logic d, input int len, output logic [DW-1:0] took);
        @(negedge clk);
        xfer_valid = 1; xfer_dir = d; xfer_len = LW'(len);
        #1 took = xfer_take;
        @(negedge clk);
        xfer_valid = 0;
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] v, t;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R13 reset state
        rd(3'd0, v); check("R13 cmd", v, 0);
        rd(3'd3, v); check("R13 wcnt", v, 0);
        rd(3'd4, v); check("R13 wadr", v, 32'hFFFFFFFF);
        rd(3'd7, v); check("R13 wdsc", v, 32'hFFFFFFFD);
        rd(3'd5, v); check("R13 stat", v, 0);
        check("R13 enable", {31'b0, xfer_enable}, 0);

        // R14 control readback, select write-one-to-clear
        ctl(32'h0100_0000);
        #1 check("R14 ctl", ctl_rdata, 32'h0100_0000);

        // R1 readback of programmable registers
        wr(3'd1, 32'h0000_0010); rd(3'd1, v); check("R1 scnt", v, 32'h10);
        wr(3'd2, 32'h8000_1000); rd(3'd2, v); check("R1 sadr", v, 32'h8000_1000);
        wr(3'd6, 32'h0000_4440); rd(3'd6, v); check("R1 sdsc", v, 32'h4440);

        // R2 working registers ignore writes
        wr(3'd3, 32'h55); rd(3'd3, v); check("R2 wcnt", v, 0);
        wr(3'd4, 32'h55); rd(3'd4, v); check("R2 wadr", v, 32'hFFFFFFFF);
        wr(3'd7, 32'h55); rd(3'd7, v); check("R2 wdsc", v, 32'hFFFFFFFD);

        // R3 start snapshot, with descriptor bit set (R4)
        wr(3'd0, 32'h13);
        check("R3 enable", {31'b0, xfer_enable}, 1);
        rd(3'd3, v); check("R3 wcnt", v, 32'h10);
        rd(3'd4, v); check("R3 wadr", v, 32'h8000_1000);
        rd(3'd7, v); check("R3 wdsc", v, 32'h4440);
        rd(3'd0, v); check("R1 cmd", v, 32'h13);

        // R6/R7 sweep over start counts and offered lengths
        for (int s = 0; s < 5; s++) begin
            int m, a, dn;
            m = s * 3; a = 32'h100 * s; dn = 0;
            wr(3'd1, DW'(m)); wr(3'd2, DW'(a)); wr(3'd0, 32'h3);
            rd(3'd5, v); check("R3 stat cleared", v, 0);
            for (int k = 0; k < 6; k++) begin
                int len, tk;
                len = (k * 3 + s) % 7;
                tk  = (len < m) ? len : m;
                xfer(1'b0, len, t); check("R6 take", t, DW'(tk));
                m = m - tk; a = a + tk;
                if (m == 0) dn = 1;
                rd(3'd3, v); check("R6 wcnt", v, DW'(m));
                rd(3'd4, v); check("R6 wadr", v, DW'(a));
                rd(3'd5, v); check("R7 done", v, DW'(dn * 8));
            end
        end

        // R8 direction mismatch, then device-to-memory
        wr(3'd1, 32'd20); wr(3'd2, 32'h2000); wr(3'd0, 32'h3);
        xfer(1'b1, 5, t); check("R8 take", t, 0);
        rd(3'd3, v); check("R8 wcnt", v, 20);
        wr(3'd0, 32'h83);
        xfer(1'b0, 5, t); check("R8 take rev", t, 0);
        xfer(1'b1, 5, t); check("R8 take d2m", t, 5);
        rd(3'd4, v); check("R8 wadr", v, 32'h2005);

        // R4 flush keeps state, idle drops enable
        wr(3'd0, 32'h81);
        check("R4 flush enable", {31'b0, xfer_enable}, 1);
        rd(3'd3, v); check("R4 flush wcnt", v, 15);
        wr(3'd0, 32'h80);
        check("R4 idle enable", {31'b0, xfer_enable}, 0);

        // R5 abort pulse
        @(negedge clk);
        reg_wr_en = 1; reg_idx = 3'd0; reg_wdata = 32'h82;
        @(negedge clk);
        reg_wr_en = 0;
        check("R5 abort high", {31'b0, core_abort}, 1);
        @(negedge clk);
        check("R5 abort low", {31'b0, core_abort}, 0);

        // R12 completion, R9 write-one-to-clear
        @(negedge clk); core_done = 1;
        @(negedge clk); core_done = 0;
        rd(3'd3, v); check("R12 wcnt", v, 0);
        rd(3'd5, v); check("R12 done", v, 8);
        wr(3'd5, 32'h0); rd(3'd5, v); check("R9 zero write", v, 8);
        wr(3'd5, 32'h8); rd(3'd5, v); check("R9 cleared", v, 0);

        // R11 live core interrupt, not stored
        core_irq = 1; rd(3'd5, v); check("R11 irq high", v, 32'h10);
        core_irq = 0; rd(3'd5, v); check("R11 irq low", v, 0);

        // R10 read-to-clear; R2 status write ignored in that mode
        ctl(32'h0);
        @(negedge clk); core_done = 1;
        @(negedge clk); core_done = 0;
        wr(3'd5, 32'hE);
        rd(3'd5, v); check("R2 stat write ignored", v, 8);
        rd(3'd5, v); check("R10 cleared by read", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule